// File: doc/BRIEF.md
# Addressed Almost-Full Flag Bus Selector

This block sits on the write side of a multi-queue buffer and shares one 8-bit status bus among up to 32 per-queue almost-full flags. A write-side address with a flag strobe chooses which group of eight queues (a quadrant) the bus shows. The upper address bits carry a device number, so several such devices can sit on one shared bus and only the addressed one drives it. The bus shows the new quadrant one write-clock cycle after the edge that selected it. After that it keeps following the live status of that quadrant, again with one cycle of latency.

The operating mode is taken from a flag-mode pin while reset is held. A low level selects this addressed scheme. A high level leaves the bus to a scanning scheme outside this block, and this block then stays silent. When eight or fewer queues are configured, the block ignores the address and shows queues 0 to 7 permanently. Bus lanes that map to queues beyond the configured count read as zero. A strobe raised in the same cycle as a write-queue select breaks the protocol. The block then keeps its current quadrant and flags a one-cycle error.

All pins are plain level signals in the write-clock domain. The block has no data stream, so it has no valid/ready handshake and no back-pressure. The bus enable is the only qualifier on the bus.

Top module: `flag_quad_sel`

## Requirements
- R1: After reset with the flag-mode pin low and more than 8 queues configured, flag_oe_o is 0, flag_bus_o is 0 and proto_err_o is 0, and they stay so until a matching selection.
- R2: On a rising edge where strobe_i is 1 and wq_sel_i is 0, addr_i[1:0] becomes the quadrant q. From the second rising edge onward, flag_bus_o bit i equals status_i[q*8+i].
- R3: A new quadrant may be selected on every consecutive edge. The bus then shows each selection one cycle after the edge that captured it.
- R4: The device number is addr_i[7:5]. When it equals dev_id_i, flag_oe_o becomes 1 one cycle after the capture edge. Otherwise flag_oe_o becomes 0 and flag_bus_o becomes 0.
- R5: Without a strobe the selection is held, and a change on status_i within the selected quadrant reaches flag_bus_o one edge later.
- R6: A strobe together with wq_sel_i leaves the quadrant and the enable unchanged. proto_err_o is then 1 for exactly the cycle after that edge.
- R7: With cfg_nq_i at 8 or less, the bus shows queues 0 to 7 and flag_oe_o is 1 from the second edge after reset, whatever the address or device number.
- R8: Bus lane i reads 0 whenever q*8+i is not below cfg_nq_i.
- R9: With flag_mode_i high during reset, flag_oe_o and flag_bus_o stay 0 and strobes have no effect.
- R10: addr_i[4:2] has no effect on the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low reset; the flag-mode pin is sampled while it is low |
| flag_mode_i | input | 1 | 0 selects addressed mode, 1 leaves the bus to the scanning scheme |
| dev_id_i | input | 3 | Static device number of this device |
| cfg_nq_i | input | 6 | Number of configured queues, 1 to 32 |
| status_i | input | 32 | Almost-full flag of each queue |
| addr_i | input | 8 | Write-side address: [7:5] device, [1:0] quadrant |
| strobe_i | input | 1 | Flag strobe that requests a quadrant selection |
| wq_sel_i | input | 1 | Write-queue select on the same address bus |
| flag_bus_o | output | 8 | Shared flag bus lanes, 0 when not enabled |
| flag_oe_o | output | 1 | Bus drive enable for this device |
| proto_err_o | output | 1 | One-cycle pulse after a strobe that collided with a write-queue select |

## Verification
The hardest case to reach is the one where a selection and the live status change in overlapping cycles. Here the registered bus has to show the old quadrant for exactly one more edge. The bench reaches it with back-to-back strobes on successive edges, sampling between them. It then changes the status while the strobe is idle. The other hard cases are the ones that need a new reset: the small-configuration bypass and the scanning-mode silence. The bench reruns reset with different mode and count inputs to reach them.

// File: rtl/fqs_pkg.sv
package fqs_pkg;

  typedef enum logic {
    FQS_ADDRESSED = 1'b0,
    FQS_POLLED    = 1'b1
  } fqs_mode_e;

  // a lane is live when its queue index lies below the configured count
  function automatic logic fqs_lane_live(input int quad, input int lane,
                                         input int lanes, input int count);
    return (quad * lanes + lane) < count;
  endfunction

endpackage

// File: rtl/fqs_addr_decode.sv
module fqs_addr_decode #(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 3,
  parameter int QUAD_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_i,
  input  logic              wq_sel_i,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic              active_i,
  output logic              take_o,
  output logic              conflict_o,
  output logic [QUAD_W-1:0] quad_o,
  output logic              id_hit_o
);

  logic [ID_W-1:0] addr_dev;

  always_comb begin
    addr_dev   = addr_i[ADDR_W-1 -: ID_W];
    quad_o     = addr_i[QUAD_W-1:0];
    id_hit_o   = (addr_dev == dev_id_i);
    take_o     = active_i & strobe_i & ~wq_sel_i;
    conflict_o = active_i & strobe_i &  wq_sel_i;
  end

endmodule

// File: rtl/fqs_sel_reg.sv
module fqs_sel_reg #(
  parameter int QUAD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              conflict_i,
  input  logic [QUAD_W-1:0] quad_i,
  input  logic              id_hit_i,
  input  logic              bypass_i,
  input  logic              active_i,
  output logic [QUAD_W-1:0] sel_quad_o,
  output logic              sel_hit_o,
  output logic              proto_err_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_quad_o  <= '0;
      sel_hit_o   <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      proto_err_o <= conflict_i;
      if (active_i && bypass_i) begin
        sel_quad_o <= '0;
        sel_hit_o  <= 1'b1;
      end else if (take_i) begin
        sel_quad_o <= quad_i;
        sel_hit_o  <= id_hit_i;
      end
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !bypass_i) |=> (sel_quad_o == $past(quad_i)));

  assert_conflict_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_i && !bypass_i) |=> ($stable(sel_quad_o) && $stable(sel_hit_o)));

  assert_conflict_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_i |=> proto_err_o);

  assert_no_spurious_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict_i |=> !proto_err_o);

  assert_bypass_quad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && bypass_i) |=> (sel_quad_o == '0 && sel_hit_o));

endmodule

// File: rtl/fqs_bus_mux.sv
module fqs_bus_mux #(
  parameter int NUM_Q  = 32,
  parameter int BUS_W  = 8,
  parameter int QUAD_W = 2,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_Q-1:0]  status_i,
  input  logic [CNT_W-1:0]  cfg_nq_i,
  input  logic [QUAD_W-1:0] sel_quad_i,
  input  logic              sel_hit_i,
  input  logic              active_i,
  output logic [BUS_W-1:0]  bus_o,
  output logic              oe_o
);

  localparam int NQUAD = NUM_Q / BUS_W;

  logic [BUS_W-1:0] group [NQUAD];
  logic [BUS_W-1:0] picked;
  logic [BUS_W-1:0] masked;

  for (genvar g = 0; g < NQUAD; g++) begin : g_group
    assign group[g] = status_i[g*BUS_W +: BUS_W];
  end

  always_comb begin
    picked = '0;
    for (int g = 0; g < NQUAD; g++) begin
      if (int'(sel_quad_i) == g) picked = group[g];
    end
    for (int i = 0; i < BUS_W; i++) begin
      masked[i] = picked[i] &
        fqs_pkg::fqs_lane_live(int'(sel_quad_i), i, BUS_W, int'(cfg_nq_i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_o <= '0;
      oe_o  <= 1'b0;
    end else begin
      oe_o  <= active_i & sel_hit_i;
      bus_o <= (active_i & sel_hit_i) ? masked : '0;
    end
  end

  assert_oe_follows_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && sel_hit_i) |=> oe_o);

  assert_oe_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hit_i |=> !oe_o);

  assert_quiet_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> (bus_o == '0));

  assert_track_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && $stable(sel_quad_i) && $stable(status_i) && $stable(cfg_nq_i)
     && $past(oe_o)) |=> $stable(bus_o));

endmodule

// File: rtl/flag_quad_sel.sv
module flag_quad_sel #(
  parameter int NUM_Q  = 32,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 8,
  parameter int ID_W   = 3,
  localparam int QUAD_W = $clog2(NUM_Q / BUS_W),
  localparam int CNT_W  = $clog2(NUM_Q + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_mode_i,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic [CNT_W-1:0]  cfg_nq_i,
  input  logic [NUM_Q-1:0]  status_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_i,
  input  logic              wq_sel_i,
  output logic [BUS_W-1:0]  flag_bus_o,
  output logic              flag_oe_o,
  output logic              proto_err_o
);

  fqs_pkg::fqs_mode_e mode_r;
  logic               active;
  logic               bypass;
  logic               take, conflict, id_hit, sel_hit;
  logic [QUAD_W-1:0]  dec_quad, sel_quad;

  // mode is sampled for as long as reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_r <= fqs_pkg::fqs_mode_e'(flag_mode_i);
  end

  assign active = (mode_r == fqs_pkg::FQS_ADDRESSED);
  assign bypass = (cfg_nq_i <= CNT_W'(BUS_W));

  fqs_addr_decode #(.ADDR_W(ADDR_W), .ID_W(ID_W), .QUAD_W(QUAD_W)) u_dec (
    .addr_i(addr_i), .strobe_i(strobe_i), .wq_sel_i(wq_sel_i),
    .dev_id_i(dev_id_i), .active_i(active),
    .take_o(take), .conflict_o(conflict), .quad_o(dec_quad), .id_hit_o(id_hit)
  );

  fqs_sel_reg #(.QUAD_W(QUAD_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .take_i(take), .conflict_i(conflict),
    .quad_i(dec_quad), .id_hit_i(id_hit), .bypass_i(bypass), .active_i(active),
    .sel_quad_o(sel_quad), .sel_hit_o(sel_hit), .proto_err_o(proto_err_o)
  );

  fqs_bus_mux #(.NUM_Q(NUM_Q), .BUS_W(BUS_W), .QUAD_W(QUAD_W), .CNT_W(CNT_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .cfg_nq_i(cfg_nq_i),
    .sel_quad_i(sel_quad), .sel_hit_i(sel_hit), .active_i(active),
    .bus_o(flag_bus_o), .oe_o(flag_oe_o)
  );

  assert_scan_mode_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!flag_oe_o && flag_bus_o == '0));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!proto_err_o));

endmodule

// File: tb/test_flag_quad_sel.sv
module test_flag_quad_sel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flag_mode_i;
  logic [2:0]  dev_id_i;
  logic [5:0]  cfg_nq_i;
  logic [31:0] status_i;
  logic [7:0]  addr_i;
  logic        strobe_i;
  logic        wq_sel_i;
  logic [7:0]  flag_bus_o;
  logic        flag_oe_o;
  logic        proto_err_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  localparam logic [31:0] STAT = 32'h965A_3CE1;

  // {address, expected bus, expected enable}; device number 3'b101
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {8'hA0, 8'hE1, 1'b1},
    {8'hA3, 8'h96, 1'b1},
    {8'hBD, 8'h3C, 1'b1},   // middle bits set (R10)
    {8'hA2, 8'h5A, 1'b1},
    {8'h23, 8'h00, 1'b0},   // other device
    {8'hE2, 8'h00, 1'b0},   // other device
    {8'hA2, 8'h5A, 1'b1},
    {8'hBF, 8'h96, 1'b1}
  };

  always #4 clk = ~clk;  // 125 MHz

  flag_quad_sel i_flag_quad_sel (
    .clk(clk), .rst_n(rst_n), .flag_mode_i(flag_mode_i), .dev_id_i(dev_id_i),
    .cfg_nq_i(cfg_nq_i), .status_i(status_i), .addr_i(addr_i),
    .strobe_i(strobe_i), .wq_sel_i(wq_sel_i), .flag_bus_o(flag_bus_o),
    .flag_oe_o(flag_oe_o), .proto_err_o(proto_err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic fm, input logic [5:0] nq);
    @(negedge clk);
    rst_n = 1'b0; flag_mode_i = fm; cfg_nq_i = nq;
    strobe_i = 1'b0; wq_sel_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // strobe for one edge, then sample just after the following edge
  task automatic select(input logic [7:0] a);
    @(negedge clk);
    addr_i = a; strobe_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    dev_id_i = 3'b101; status_i = STAT; addr_i = '0;
    do_reset(1'b0, 6'd32);
    @(negedge clk);
    check("R1 oe", 32'(flag_oe_o), 0);
    check("R1 bus", 32'(flag_bus_o), 0);
    check("R1 err", 32'(proto_err_o), 0);

    for (int v = 0; v < NV; v++) begin
      select(VEC[v][16:9]);
      check("R2/R4/R10 bus", 32'(flag_bus_o), 32'(VEC[v][8:1]));
      check("R2/R4 oe", 32'(flag_oe_o), 32'(VEC[v][0]));
    end

    // R3: strobes on consecutive edges
    @(negedge clk); addr_i = 8'hA1; strobe_i = 1'b1;
    @(negedge clk); addr_i = 8'hA2;
    @(negedge clk); check("R3 first", 32'(flag_bus_o), 32'h3C);
    addr_i = 8'hA3;
    @(negedge clk); check("R3 second", 32'(flag_bus_o), 32'h5A);
    strobe_i = 1'b0;
    @(negedge clk); check("R3 third", 32'(flag_bus_o), 32'h96);

    // R5: selection held, live status tracked
    status_i = 32'h1122_3344;
    @(posedge clk); #1;
    check("R5 tracked", 32'(flag_bus_o), 32'h11);

    // R6: strobe colliding with write-queue select
    @(negedge clk);
    status_i = STAT; addr_i = 8'hA0; strobe_i = 1'b1; wq_sel_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0; wq_sel_i = 1'b0;
    check("R6 pulse", 32'(proto_err_o), 1);
    @(negedge clk);
    check("R6 pulse ends", 32'(proto_err_o), 0);
    check("R6 quad kept", 32'(flag_bus_o), 32'h96);
    check("R6 oe kept", 32'(flag_oe_o), 1);

    // R8: lanes past the configured count
    cfg_nq_i = 6'd26;
    select(8'hA3);
    check("R8 26 queues", 32'(flag_bus_o), 32'h02);
    cfg_nq_i = 6'd20;
    select(8'hA2);
    check("R8 20 queues", 32'(flag_bus_o), 32'h0A);

    // R7: small configuration bypass
    cfg_nq_i = 6'd8;
    select(8'hA3);
    check("R7 bus", 32'(flag_bus_o), 32'hE1);
    select(8'h23);
    check("R7 foreign id bus", 32'(flag_bus_o), 32'hE1);
    check("R7 foreign id oe", 32'(flag_oe_o), 1);
    do_reset(1'b0, 6'd4);
    @(posedge clk); @(posedge clk); #1;
    check("R7 oe after reset", 32'(flag_oe_o), 1);
    check("R7/R8 bus 4 queues", 32'(flag_bus_o), 32'h01);

    // R9: scanning mode leaves the bus alone
    do_reset(1'b1, 6'd32);
    select(8'hA0);
    check("R9 oe", 32'(flag_oe_o), 0);
    check("R9 bus", 32'(flag_bus_o), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule